// File: doc/BRIEF.md
# MAC Address Hash Unit

This unit turns a 48-bit Ethernet station address into an 8-bit bucket index for a switch forwarding table. The index comes from a CRC-style shift register with generator x^8 + x^2 + x + 1. The register starts from a fixed non-zero value. Each data bit is merged in at the top of the register rather than appended after the data, and no trailing zeros are shifted through at the end. The results are therefore intentionally different from common CRC-8 calculators.

The address enters through a valid/ready handshake. A transfer takes place on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the unit is idle. While a hash is in progress the upstream side is held off: any `in_valid` it raises is not taken and has no effect. The result leaves as a one-cycle `hash_valid` pulse, and `hash_out` then keeps that value until the next result. The output side has no back-pressure.

The parameter `STEP_BITS` sets how many address bits are folded per clock. It must divide 48 and leave at least two steps. The default of 1 gives a bit-serial engine that takes 48 cycles. A value of 8 folds one byte per cycle and takes 6 cycles.

Top module: `mac_hash_unit`

## Requirements
- R1: On acceptance the working hash is preset to 0x12. Each address bit b updates it as follows: form the 9-bit value {b, hash}; if bit 0 of that value is 1, XOR it with 0x1C0; the new hash is bits 8:1 of the result.
- R2: `in_addr[47:40]` is byte 0 and is folded first, and `in_addr[7:0]` is byte 5 and is folded last. Within each byte, bit 0 is folded first.
- R3: The result is the hash after the 48th bit, with no extra zero bits. Address 0x101112131415 gives 0xC2, and address 0x1011CCDDEE00 gives 0xE6.
- R4: `in_ready` equals NOT `busy`. A transfer on `in_valid && in_ready` captures `in_addr` and raises `busy` on the same edge.
- R5: While `busy` is high, `in_valid` is not taken. A different address offered then changes neither the result nor the completion time.
- R6: `hash_valid` is high for exactly one cycle. This happens 48/STEP_BITS clock edges after the accepting edge, in the same cycle that `busy` falls.
- R7: `hash_out` changes only in a cycle where `hash_valid` is high, and otherwise holds its last value.
- R8: A synchronous active-high `rst` forces `busy` and `hash_valid` low and `hash_out` to 0, including in the middle of a hash.
- R9: STEP_BITS = 8 gives the same result as the bit-serial default, delivered after 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Unit idle, address will be taken |
| in_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| busy | output | 1 | Hash in progress |
| hash_valid | output | 1 | One-cycle pulse, hash_out is new |
| hash_out | output | 8 | Bucket index, held between results |

## Verification
The hardest condition to create from the ports is an address that is offered while a hash is still in progress. The bench must prove that this address leaves no trace, because if it were taken by mistake it would quietly restart the engine or change the remaining bits. The stimulus therefore raises `in_valid` with the complemented address partway through each injected run. It then requires the original hash at the original cycle, with `busy` still high in the cycle after. The bench also sweeps every value of byte 0, walks a single one through all 48 address bits to pin down the bit order, and applies a reset in the middle of a hash. A byte-per-cycle instance runs in parallel on the same addresses.

// File: rtl/mhash_pkg.sv
package mhash_pkg;
  localparam int ADDR_BITS  = 48;
  localparam int BYTE_BITS  = 8;
  localparam int ADDR_BYTES = ADDR_BITS / BYTE_BITS;
  localparam int HASH_BITS  = 8;

  typedef logic [HASH_BITS-1:0] hash_t;

  localparam hash_t            SEED = 8'h12;
  localparam logic [HASH_BITS:0] FOLD = 9'h1C0;

  // One bit step: merge bit at the top, conditionally fold, shift right.
  function automatic hash_t hash_bit(hash_t s, logic b);
    logic [HASH_BITS:0] r;
    r = {b, s};
    if (r[0]) r = r ^ FOLD;
    return r[HASH_BITS:1];
  endfunction
endpackage

// File: rtl/mhash_step.sv
module mhash_step
  import mhash_pkg::*;
#(
  parameter int STEP_BITS = 1
) (
  input  hash_t                s_in,
  input  logic [STEP_BITS-1:0] bits,
  output hash_t                s_out
);
  hash_t chain [STEP_BITS+1];

  assign chain[0] = s_in;

  for (genvar i = 0; i < STEP_BITS; i++) begin : g_bit
    assign chain[i+1] = hash_bit(chain[i], bits[i]);
  end

  assign s_out = chain[STEP_BITS];
endmodule

// File: rtl/mhash_feed.sv
module mhash_feed
  import mhash_pkg::*;
#(
  parameter int STEP_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 adv,
  input  logic [ADDR_BITS-1:0] addr,
  output logic [STEP_BITS-1:0] bits
);
  logic [ADDR_BITS-1:0] ordered;
  logic [ADDR_BITS-1:0] stream_q;

  // Wire order: byte 0 sits in addr[47:40]; bit 0 of ordered is folded first.
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    assign ordered[b*BYTE_BITS +: BYTE_BITS] =
      addr[(ADDR_BYTES-1-b)*BYTE_BITS +: BYTE_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst)       stream_q <= '0;
    else if (load) stream_q <= ordered;
    else if (adv)  stream_q <= stream_q >> STEP_BITS;
  end

  assign bits = stream_q[STEP_BITS-1:0];
endmodule

// File: rtl/mhash_seq.sv
module mhash_seq #(
  parameter int STEPS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last,
  output logic done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(STEPS - 1);

  logic [CW-1:0] count;

  assign last = busy && (count == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (start && !busy) begin
        busy  <= 1'b1;
        count <= '0;
      end else if (busy) begin
        if (count == LAST_C) begin
          busy  <= 1'b0;
          count <= '0;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  assert_take_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && count == '0));

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && start && count != LAST_C) |=> (busy && count == $past(count) + 1'b1));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (done && STEPS > 1) |=> !done);

  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    count <= LAST_C);
endmodule

// File: rtl/mac_hash_unit.sv
module mac_hash_unit
  import mhash_pkg::*;
#(
  parameter int STEP_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_BITS-1:0] in_addr,
  output logic                 busy,
  output logic                 hash_valid,
  output logic [HASH_BITS-1:0] hash_out
);
  localparam int STEPS = ADDR_BITS / STEP_BITS;

  logic                 accept;
  logic                 last;
  logic [STEP_BITS-1:0] bits;
  hash_t                state_q;
  hash_t                state_nx;
  hash_t                hash_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  mhash_seq #(.STEPS(STEPS)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(in_valid),
    .busy (busy),
    .last (last),
    .done (hash_valid)
  );

  mhash_feed #(.STEP_BITS(STEP_BITS)) u_feed (
    .clk (clk),
    .rst (rst),
    .load(accept),
    .adv (busy),
    .addr(in_addr),
    .bits(bits)
  );

  mhash_step #(.STEP_BITS(STEP_BITS)) u_step (
    .s_in (state_q),
    .bits (bits),
    .s_out(state_nx)
  );

  always_ff @(posedge clk) begin
    if (rst)         state_q <= SEED;
    else if (accept) state_q <= SEED;
    else if (busy)   state_q <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (rst)       hash_q <= '0;
    else if (last) hash_q <= state_nx;
  end

  assign hash_out = hash_q;

  assert_seed_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state_q == SEED));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hash_valid || $stable(hash_out)));

  assert_ready_R4: assert property (@(posedge clk) disable iff (rst)
    in_ready != busy);
endmodule

// File: tb/sim_mac_hash_unit.sv
module sim_mac_hash_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v0 = 1'b0, v1 = 1'b0;
  logic [47:0] addr_drv = '0;
  logic        rdy0, rdy1, busy0, busy1, hv0, hv1;
  logic [7:0]  h0, h1;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_hash_unit #(.STEP_BITS(1)) u0 (
    .clk(clk), .rst(rst), .in_valid(v0), .in_ready(rdy0), .in_addr(addr_drv),
    .busy(busy0), .hash_valid(hv0), .hash_out(h0));

  mac_hash_unit #(.STEP_BITS(8)) u1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(rdy1), .in_addr(addr_drv),
    .busy(busy1), .hash_valid(hv1), .hash_out(h1));

  function automatic logic [7:0] ref_hash(logic [47:0] a);
    logic [7:0] s;
    logic [8:0] r;
    s = 8'h12;
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 8; k++) begin
        r = {a[47 - 8*b - 7 + k], s};
        if (r[0]) r = r ^ 9'h1C0;
        s = r[8:1];
      end
    end
    return s;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [47:0] a, input string req, input bit inject);
    logic [7:0] e;
    e = ref_hash(a);
    @(negedge clk);
    addr_drv = a; v0 = 1'b1; v1 = 1'b1;
    chk(rdy0 && rdy1, "R4 ready when idle", {rdy0, rdy1}, 2'b11);
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    chk(busy0 && !rdy0, "R4 busy after take", {busy0, rdy0}, 2'b10);
    for (int k = 1; k <= 49; k++) begin
      @(negedge clk);
      if (inject && k == 10) begin addr_drv = ~a; v0 = 1'b1; end
      if (inject && k == 11) begin
        v0 = 1'b0;
        chk(busy0 && !hv0, "R5 offer while busy ignored", {busy0, hv0}, 2'b10);
      end
      if (k == 6) chk(hv1 && h1 == e, "R9 byte-per-cycle result", {hv1, h1}, {1'b1, e});
      if (k == 7) chk(!hv1 && h1 == e, "R6 R7 byte variant pulse/hold", {hv1, h1}, {1'b0, e});
      if (k == 47) chk(!hv0 && busy0, "R6 not early", {hv0, busy0}, 2'b01);
      if (k == 48) chk(hv0 && h0 == e && rdy0, req, {hv0, h0, rdy0}, {1'b1, e, 1'b1});
      if (k == 49) chk(!hv0 && h0 == e, "R6 R7 one-cycle pulse, value held", {hv0, h0}, {1'b0, e});
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R6 act=timeout exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdy0 && !busy0 && !hv0 && h0 == 8'h00, "R8 reset state", {rdy0, busy0, hv0, h0},
        {1'b1, 1'b0, 1'b0, 8'h00});

    // R3: stated reference vectors, constants independent of the model
    run_one(48'h101112131415, "R3 vector A", 1'b0);
    chk(h0 == 8'hC2, "R3 vector A constant", h0, 8'hC2);
    run_one(48'h1011CCDDEEDD & 48'hFFFFFFFFFF00, "R3 vector B", 1'b0);
    chk(h0 == 8'hE6, "R3 vector B constant", h0, 8'hE6);

    // R1: every value of the first byte
    for (int v = 0; v < 256; v++)
      run_one({v[7:0], 40'h0123456789}, "R1 byte-0 sweep", 1'b0);

    // R2: a single one walked through every address bit
    for (int i = 0; i < 48; i++)
      run_one(48'h1 << i, "R2 walking one", 1'b0);

    // R5: foreign address offered mid-run
    seed = 64'h9E3779B97F4A7C15;
    for (int n = 0; n < 24; n++) begin
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      run_one(seed[63:16], "R5 result unaffected by offer", 1'b1);
    end

    // R8: reset in the middle of a hash
    @(negedge clk);
    addr_drv = 48'hA5A5_0F0F_3C3C; v0 = 1'b1;
    @(negedge clk);
    v0 = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(rdy0 && !busy0 && !hv0 && h0 == 8'h00, "R8 mid-run reset", {rdy0, busy0, hv0, h0},
        {1'b1, 1'b0, 1'b0, 8'h00});
    repeat (40) @(negedge clk);
    chk(!hv0 && h0 == 8'h00, "R8 no late result after reset", {hv0, h0}, 9'h000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule